// File: doc/BRIEF.md
# Translation Lookaside Buffer with Protection

This block is a small, fully associative store of recent page translations that sits in front of a page table walker. Each cycle it can take one lookup: a virtual page number, the page offset, an access kind (read or write) and the privilege of the requester (user or kernel). One cycle later it returns one of three outcomes. A hit returns the physical address, built from the stored physical page number and the page offset passed through unchanged. A fault means the access is not allowed. A miss means a walk is needed, and the block raises a walk request that carries the virtual page number.

Every entry stores a tag, a physical page number and four attribute bits: readable, writable, dirty and user-accessible. Because these bits sit next to the tag, the permission decision and the dirty decision are made in the same cycle as the match. A write to a clean page is reported as a miss, so that the walker can mark the page dirty in memory and then refill the entry. The walker answers through a fill port. A fill replaces an entry that already holds the same page. If no entry holds that page, the fill goes to the lowest free slot, and once the buffer is full it goes to the slot named by a round-robin pointer. A flush input empties the whole buffer in one cycle when the address space changes.

Top module: `tlb_prot`

## Requirements
- R1: After a synchronous reset, no entry is valid, `resp_valid` and `walk_req` are low, and every lookup misses.
- R2: A lookup presented in cycle N gets its response in cycle N+1. On a hit, `resp_pa` equals the stored physical page number in the upper bits, followed by `req_off` unchanged in the low OFF_W bits.
- R3: A lookup that matches no valid entry gives `resp_miss`, together with `walk_req` and `walk_vpn` equal to the requested page number.
- R4: A fill installs its page number, physical page number and attributes, and a later lookup of that page uses them.
- R5: A read of a page whose readable bit is clear faults. A write of a page whose writable bit is clear faults.
- R6: A user-mode access (`req_user`=1) to a page whose user bit is clear faults. A kernel-mode access is never refused on the user bit.
- R7: A write that passes the permission checks on a page whose dirty bit is clear gives `resp_miss` and `walk_req`. After a refill with the dirty bit set, the same write hits.
- R8: A permission fault takes priority over the clean-write miss, and a fault never raises `walk_req`.
- R9: While free slots exist, a fill of a new page takes the lowest-indexed free slot, so filling an empty buffer of ENTRIES pages evicts nothing.
- R10: When the buffer is full, fills of new pages replace slots 0, 1, 2 and so on in order, wrapping to 0 after the last slot.
- R11: A fill for a page that is already present overwrites that entry in place, neither taking a new slot nor moving the round-robin pointer.
- R12: `flush` invalidates every entry in one cycle and resets the round-robin pointer. A fill in the same cycle as a flush is dropped.
- R13: Exactly one of `resp_hit`, `resp_miss` and `resp_fault` is high when `resp_valid` is high, and none is high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Lookup present this cycle |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_off | input | OFF_W | Page offset, passed through |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_user | input | 1 | 1 = user mode, 0 = kernel mode |
| resp_valid | output | 1 | Response for last cycle's lookup |
| resp_hit | output | 1 | Translation allowed and present |
| resp_miss | output | 1 | Walk needed (absent or clean write) |
| resp_fault | output | 1 | Protection violation |
| resp_pa | output | PPN_W+OFF_W | Physical address on hit |
| walk_req | output | 1 | Request a page table walk |
| walk_vpn | output | VPN_W | Page number to walk |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_ppn | input | PPN_W | Physical page number of the fill |
| fill_rd | input | 1 | Readable bit |
| fill_wr | input | 1 | Writable bit |
| fill_dirty | input | 1 | Dirty bit |
| fill_user | input | 1 | User-accessible bit |

## Verification
The bench sweeps all 64 combinations of the four attribute bits, the access kind and the privilege mode on a single installed page, and computes the expected outcome arithmetically. A design that ranks the clean-write miss above a fault, or that checks the user bit in kernel mode, gives the wrong outcome for some of those combinations. A second sequence fills a four-entry buffer and then keeps replacing. Through hits and misses at the ports, it shows which page each fill evicted: a design whose pointer does not wrap, or that moves the pointer or takes a new slot on a same-page refill, evicts the wrong page. A flush issued in the same cycle as a fill checks that the fill is dropped and that both pages then miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // Attribute bits held beside every tag
  typedef struct packed {
    logic rd;     // page readable
    logic wr;     // page writable
    logic dirty;  // page already marked modified
    logic usr;    // page reachable from user mode
  } tlb_attr_t;
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic                        wr_en,
  input  logic [$clog2(ENTRIES)-1:0]  wr_idx,
  input  logic [VPN_W-1:0]            wr_vpn,
  input  logic [PPN_W-1:0]            wr_ppn,
  input  tlb_pkg::tlb_attr_t          wr_attr,
  input  logic [VPN_W-1:0]            lk_vpn,
  output logic [ENTRIES-1:0]          lk_match,
  output logic [PPN_W-1:0]            lk_ppn,
  output tlb_pkg::tlb_attr_t          lk_attr,
  input  logic [VPN_W-1:0]            fl_vpn,
  output logic [ENTRIES-1:0]          fl_match,
  output logic [ENTRIES-1:0]          valid_vec
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]  valid_q;
  logic [VPN_W-1:0]    tag_mem  [ENTRIES];
  logic [PPN_W-1:0]    ppn_mem  [ENTRIES];
  tlb_pkg::tlb_attr_t  attr_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst || flush) valid_q <= '0;
    else if (wr_en)   valid_q[wr_idx] <= 1'b1;
  end

  // payload written at one index per cycle, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_vpn;
      ppn_mem[wr_idx]  <= wr_ppn;
      attr_mem[wr_idx] <= wr_attr;
    end
  end

  // two parallel comparators per slot: lookup and fill
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = valid_q[g] && (tag_mem[g] == lk_vpn);
    assign fl_match[g] = valid_q[g] && (tag_mem[g] == fl_vpn);
  end

  always_comb begin
    lk_ppn  = '0;
    lk_attr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) begin
        lk_ppn  = lk_ppn | ppn_mem[i];
        lk_attr = lk_attr | attr_mem[i];
      end
    end
  end

  assign valid_vec = valid_q;

  // R11
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));
  // R12
  flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_vec == '0));
  // R4
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> valid_vec[$past(wr_idx)]);

  logic unused_idx;
  assign unused_idx = ^IDX_W;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        flush,
  input  logic                        fill_en,
  input  logic [ENTRIES-1:0]          valid_vec,
  input  logic [ENTRIES-1:0]          fl_match,
  output logic [$clog2(ENTRIES)-1:0]  vic_idx
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q, same_idx, free_idx;
  logic             same_any, full;

  always_comb begin
    same_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (fl_match[i]) same_idx = IDX_W'(i);
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_vec[i]) free_idx = IDX_W'(i);
  end

  assign same_any = |fl_match;
  assign full     = &valid_vec;
  assign vic_idx  = same_any ? same_idx : (!full ? free_idx : ptr_q);

  always_ff @(posedge clk) begin
    if (rst || flush)
      ptr_q <= '0;
    else if (fill_en && !same_any && full)
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  // R9
  free_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !same_any && !full) |-> !valid_vec[vic_idx]);
  // R11
  same_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && same_any) |-> fl_match[vic_idx]);
  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst || flush)
    (!fill_en) |=> $stable(ptr_q));
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check (
  input  tlb_pkg::tlb_attr_t attr,
  input  logic               is_write,
  input  logic               is_user,
  output logic               fault,
  output logic               need_dirty
);
  logic mode_bad, kind_bad;

  assign mode_bad   = is_user && !attr.usr;
  assign kind_bad   = is_write ? !attr.wr : !attr.rd;
  assign fault      = mode_bad || kind_bad;
  // clean-write walk only when permissions pass
  assign need_dirty = !fault && is_write && !attr.dirty;
endmodule

// File: rtl/tlb_prot.sv
module tlb_prot #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 18,
  parameter int OFF_W   = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic                     req_valid,
  input  logic [VPN_W-1:0]         req_vpn,
  input  logic [OFF_W-1:0]         req_off,
  input  logic                     req_write,
  input  logic                     req_user,
  output logic                     resp_valid,
  output logic                     resp_hit,
  output logic                     resp_miss,
  output logic                     resp_fault,
  output logic [PPN_W+OFF_W-1:0]   resp_pa,
  output logic                     walk_req,
  output logic [VPN_W-1:0]         walk_vpn,
  input  logic                     fill_valid,
  input  logic [VPN_W-1:0]         fill_vpn,
  input  logic [PPN_W-1:0]         fill_ppn,
  input  logic                     fill_rd,
  input  logic                     fill_wr,
  input  logic                     fill_dirty,
  input  logic                     fill_user
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]  lk_match, fl_match, valid_vec;
  logic [PPN_W-1:0]    lk_ppn;
  tlb_pkg::tlb_attr_t  lk_attr, fill_attr;
  logic [IDX_W-1:0]    vic_idx;
  logic                fill_en, present, perm_fault, dirty_walk;
  logic                nx_hit, nx_miss, nx_fault;

  assign fill_en   = fill_valid && !flush;
  assign fill_attr = '{rd: fill_rd, wr: fill_wr, dirty: fill_dirty, usr: fill_user};

  tlb_entry_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_array (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(fill_en), .wr_idx(vic_idx), .wr_vpn(fill_vpn), .wr_ppn(fill_ppn),
    .wr_attr(fill_attr),
    .lk_vpn(req_vpn), .lk_match(lk_match), .lk_ppn(lk_ppn), .lk_attr(lk_attr),
    .fl_vpn(fill_vpn), .fl_match(fl_match), .valid_vec(valid_vec)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .flush(flush), .fill_en(fill_en),
    .valid_vec(valid_vec), .fl_match(fl_match), .vic_idx(vic_idx)
  );

  tlb_perm_check u_perm (
    .attr(lk_attr), .is_write(req_write), .is_user(req_user),
    .fault(perm_fault), .need_dirty(dirty_walk)
  );

  assign present  = |lk_match;
  assign nx_fault = present && perm_fault;
  assign nx_miss  = !present || dirty_walk;
  assign nx_hit   = present && !perm_fault && !dirty_walk;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_miss  <= 1'b0;
      resp_fault <= 1'b0;
      walk_req   <= 1'b0;
      resp_pa    <= '0;
      walk_vpn   <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_hit   <= req_valid && nx_hit;
      resp_miss  <= req_valid && nx_miss;
      resp_fault <= req_valid && nx_fault;
      walk_req   <= req_valid && nx_miss;
      if (req_valid) begin
        resp_pa  <= {lk_ppn, req_off};
        walk_vpn <= req_vpn;
      end
    end
  end

  // R13
  one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $onehot({resp_hit, resp_miss, resp_fault}));
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !resp_valid |-> !(resp_hit || resp_miss || resp_fault || walk_req));
  // R2
  resp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (resp_pa[OFF_W-1:0] == $past(req_off)));
  // R3
  walk_page_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (walk_vpn == $past(req_vpn)));
  // R8
  fault_no_walk_chk: assert property (@(posedge clk) disable iff (rst)
    resp_fault |-> !walk_req);
endmodule

// File: tb/tlb_prot_test.sv
module tlb_prot_test;
  localparam int EN = 4, VW = 6, PW = 5, OW = 4;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [VW-1:0] req_vpn = '0;
  logic [OW-1:0] req_off = '0;
  logic resp_valid, resp_hit, resp_miss, resp_fault, walk_req;
  logic [PW+OW-1:0] resp_pa;
  logic [VW-1:0] walk_vpn;
  logic fill_valid = 1'b0, fill_rd = 1'b0, fill_wr = 1'b0, fill_dirty = 1'b0, fill_user = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [PW-1:0] fill_ppn = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tlb_prot #(.ENTRIES(EN), .VPN_W(VW), .PPN_W(PW), .OFF_W(OW)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // outcome code: 0 hit, 1 miss, 2 fault, 3 none or several
  function automatic int code();
    case ({resp_hit, resp_miss, resp_fault})
      3'b100: return 0;
      3'b010: return 1;
      3'b001: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic lookup(input int vpn, input int off, input bit w, input bit u);
    @(negedge clk);
    req_valid = 1'b1; req_vpn = VW'(vpn); req_off = OW'(off);
    req_write = w; req_user = u;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic fill(input int vpn, input int ppn, input bit r, input bit w,
                      input bit d, input bit u);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = VW'(vpn); fill_ppn = PW'(ppn);
    fill_rd = r; fill_wr = w; fill_dirty = d; fill_user = u;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  task automatic expect_hit(input string req, input int vpn, input int ppn);
    lookup(vpn, vpn & 15, 1'b0, 1'b0);
    chk(req, code(), 0);
    if (resp_hit) chk(req, int'(resp_pa), (ppn << OW) | (vpn & 15));
  endtask

  task automatic expect_miss(input string req, input int vpn);
    lookup(vpn, 0, 1'b0, 1'b0);
    chk(req, code(), 1);
    chk(req, int'(walk_vpn), vpn);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 resp_valid", int'(resp_valid), 0);
    chk("R1 walk_req", int'(walk_req), 0);
    lookup(5, 3, 1'b0, 1'b0);
    chk("R1 empty lookup", code(), 1);
    chk("R3 walk_req on miss", int'(walk_req), 1);
    chk("R3 walk_vpn", int'(walk_vpn), 5);

    // R5 R6 R7 R8 sweep over attributes, access kind, privilege
    for (int c = 0; c < 64; c++) begin
      bit r, w, d, usr, wr_acc, umode, flt;
      int exp;
      r = c[3]; w = c[2]; d = c[1]; usr = c[0]; wr_acc = c[4]; umode = c[5];
      do_flush();
      fill(c, (c ^ 21) & 31, r, w, d, usr);
      lookup(c, c & 15, wr_acc, umode);
      flt = (umode && !usr) || (wr_acc ? !w : !r);
      exp = flt ? 2 : ((wr_acc && !d) ? 1 : 0);
      chk("R5 R6 R7 R8 outcome", code(), exp);
      chk("R8 walk only on miss", int'(walk_req), int'(exp == 1));
      if (exp == 0)
        chk("R2 R4 physical address", int'(resp_pa), (((c ^ 21) & 31) << OW) | (c & 15));
    end

    // R7 clean write then dirty refill
    do_flush();
    fill(40, 7, 1, 1, 0, 1);
    lookup(40, 9, 1'b1, 1'b1);
    chk("R7 clean write miss", code(), 1);
    fill(40, 7, 1, 1, 1, 1);
    lookup(40, 9, 1'b1, 1'b1);
    chk("R7 dirty write hit", code(), 0);
    chk("R7 pa", int'(resp_pa), (7 << OW) | 9);

    // R9 free slots first, R11 refill in place, R10 round robin
    do_flush();
    for (int i = 0; i < EN; i++) fill(10 + i, 1 + i, 1, 1, 1, 1);
    for (int i = 0; i < EN; i++) expect_hit("R9 all resident", 10 + i, 1 + i);
    fill(12, 9, 1, 1, 1, 1);
    expect_hit("R11 overwrite", 12, 9);
    expect_hit("R11 neighbour kept", 10, 1);
    expect_hit("R11 neighbour kept", 13, 4);
    fill(20, 20, 1, 1, 1, 1);
    expect_miss("R10 slot0 evicted", 10);
    expect_hit("R11 pointer unmoved", 11, 2);
    expect_hit("R10 new page", 20, 20);
    fill(21, 21, 1, 1, 1, 1);
    expect_miss("R10 slot1 evicted", 11);
    fill(22, 22, 1, 1, 1, 1);
    expect_miss("R10 slot2 evicted", 12);
    expect_hit("R10 slot3 kept", 13, 4);
    fill(23, 23, 1, 1, 1, 1);
    expect_miss("R10 slot3 evicted", 13);
    fill(24, 24, 1, 1, 1, 1);
    expect_miss("R10 wrap to slot0", 20);
    expect_hit("R10 slot1 kept", 21, 21);

    // R12 flush beats simultaneous fill, pointer restarts
    fill(30, 3, 1, 1, 1, 1);
    @(negedge clk);
    flush = 1'b1; fill_valid = 1'b1; fill_vpn = VW'(31); fill_ppn = PW'(4);
    @(negedge clk);
    flush = 1'b0; fill_valid = 1'b0;
    expect_miss("R12 flushed entry", 22);
    expect_miss("R12 dropped fill", 31);
    for (int i = 0; i < EN + 1; i++) fill(50 + i, i, 1, 1, 1, 1);
    expect_miss("R12 pointer reset", 50);
    expect_hit("R12 slot1 kept", 51, 1);

    // R13 idle cycle shows no response
    @(negedge clk);
    chk("R13 idle resp_valid", int'(resp_valid), 0);
    chk("R13 idle outcome", int'({resp_hit, resp_miss, resp_fault}), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule